// File: doc/BRIEF.md
# Reversible Gate Cascade Sequencer

This block stores a short program of reversible logic gates and applies it to an 8-wire bit vector, one gate per clock cycle. Four gate kinds are supported: a multi-control inverter (all selected controls must be true for the target wire to flip), a single-control inverter, a controlled swap of two wires, and an unconditional swap of two wires. Each control term has its own polarity, so a control can require either a 1 or a 0 on its wire. Because every gate is its own inverse, running the program from the last entry back to the first undoes a forward run and returns the starting word.

Software-side logic loads descriptors through a write port and sets the program length. It then presents a word on `din`, selects the direction and pulses `start`. The sequencer walks the program, holds `busy` while gates are being applied, and raises `done` for one cycle when the result is on `dout`. The block also reports the cost of the program (the number of controlled gates, with plain swaps counted as free) and its depth (one series stage per gate).

The controller has three states. `ST_IDLE` waits for `start`. It takes the *launch* transition to `ST_STEP` when the program length is non-zero, or the *empty* transition straight to `ST_DONE` when the length is zero. `ST_STEP` applies one gate per cycle and takes the *finish* transition to `ST_DONE` after the final gate. `ST_DONE` always takes the *return* transition back to `ST_IDLE`.

Top module: `revcascade_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `dout` is 0, `cost` and `depth` are 0, and every descriptor is all-zero.
- R2: Kind 2'b00 (multi-control inverter) flips wire `wr_tgt_a` exactly when every wire selected in the control mask meets its polarity. The target wire is dropped from the mask, and an empty mask flips the target unconditionally.
- R3: A polarity bit of 1 makes that control true when its wire is 0. A polarity bit of 0 makes it true when its wire is 1.
- R4: Kind 2'b11 (single-control inverter) flips wire `wr_tgt_a` when wire `wr_tgt_b`, XOR polarity bit `wr_tgt_b`, is 1. When the two indices are equal, the gate leaves the word unchanged.
- R5: Kind 2'b01 (controlled swap) exchanges wires `wr_tgt_a` and `wr_tgt_b` when the control AND is true. Both target wires are dropped from the mask.
- R6: Kind 2'b10 (exchange) always swaps wires `wr_tgt_a` and `wr_tgt_b` and ignores both masks.
- R7: With `reverse`=0, entries are applied from 0 up to length−1. With `reverse`=1, they are applied from length−1 down to 0. A reverse run on the output of a forward run returns the original word.
- R8: With `start` sampled at edge E in idle, `busy` is high from edge E to edge E+length, and `done` is high for exactly the one cycle after edge E+length. `dout` keeps its value whenever the block is idle and not starting.
- R9: `cost` equals the number of entries below the length whose kind is not 2'b10, and `depth` equals the length. Both follow a write in the next cycle.
- R10: Descriptor writes, length writes and `start` are ignored while `busy` or `done` is high.
- R11: A length value above 16 is stored as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one gate descriptor |
| wr_addr | input | 4 | Descriptor slot |
| wr_kind | input | 2 | Gate kind (see R2, R4 to R6) |
| wr_ctrl | input | 8 | Control wire mask |
| wr_pol | input | 8 | Control polarity, 1 = negated |
| wr_tgt_a | input | 3 | First target wire index |
| wr_tgt_b | input | 3 | Second target wire, or control wire for kind 2'b11 |
| len_we | input | 1 | Write program length |
| len_val | input | 5 | Program length (saturates at 16) |
| start | input | 1 | Begin a run |
| reverse | input | 1 | 1 = run from last entry to first |
| din | input | 8 | Starting word |
| busy | output | 1 | Gates being applied |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 8 | Working and result word |
| cost | output | 5 | Number of controlled gates in the program |
| depth | output | 5 | Number of series stages |

## Verification
The result on `dout` and the `done` pulse are due `length` rising edges after the edge that samples `start`, so an empty program finishes on that same edge. `cost` and `depth` settle one edge after the write that changes them. The bench drives every input on the falling edge and advances a queue-based model on each rising edge. It then compares all five outputs against the model on the following falling edge, so every expected value is read one half-cycle after the edge that produced it. The directed checks count falling edges from `start` to `done` and compare that count with the length.

// File: rtl/revc_pkg.sv
package revc_pkg;

    typedef enum logic [1:0] {
        GK_MCT   = 2'b00,
        GK_CSWAP = 2'b01,
        GK_XCHG  = 2'b10,
        GK_CNOT1 = 2'b11
    } gate_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_STEP = 2'b01,
        ST_DONE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/revc_gate_apply.sv
module revc_gate_apply #(
    parameter int W    = 8,
    parameter int IDXW = $clog2(W)
) (
    input  logic [W-1:0]        word_i,
    input  revc_pkg::gate_kind_e kind_i,
    input  logic [W-1:0]        ctrl_i,
    input  logic [W-1:0]        pol_i,
    input  logic [IDXW-1:0]     ta_i,
    input  logic [IDXW-1:0]     tb_i,
    output logic [W-1:0]        word_o
);
    import revc_pkg::*;

    logic [W-1:0] sel_a;
    logic [W-1:0] sel_b;
    logic [W-1:0] excl;
    logic [W-1:0] eff_mask;
    logic [W-1:0] term;
    logic         and_fire;
    logic         one_fire;
    logic         bit_a;
    logic         bit_b;

    assign sel_a    = W'(1) << ta_i;
    assign sel_b    = W'(1) << tb_i;
    // target wires never act as their own controls, keeping every gate a bijection
    assign excl     = (kind_i == GK_CSWAP) ? (sel_a | sel_b) : sel_a;
    assign eff_mask = ctrl_i & ~excl;

    generate
        for (genvar i = 0; i < W; i++) begin : g_term
            assign term[i] = ~eff_mask[i] | (word_i[i] ^ pol_i[i]);
        end
    endgenerate

    assign and_fire = &term;
    assign bit_a    = word_i[ta_i];
    assign bit_b    = word_i[tb_i];
    assign one_fire = (ta_i != tb_i) && (bit_b ^ pol_i[tb_i]);

    always_comb begin
        word_o = word_i;
        unique case (kind_i)
            GK_MCT: begin
                if (and_fire) word_o[ta_i] = ~bit_a;
            end
            GK_CSWAP: begin
                if (and_fire) begin
                    word_o[ta_i] = bit_b;
                    word_o[tb_i] = bit_a;
                end
            end
            GK_XCHG: begin
                word_o[ta_i] = bit_b;
                word_o[tb_i] = bit_a;
            end
            GK_CNOT1: begin
                if (one_fire) word_o[ta_i] = ~bit_a;
            end
            default: word_o = word_i;
        endcase
    end

endmodule

// File: rtl/revc_prog_store.sv
module revc_prog_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int IDXW  = $clog2(W),
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [1:0]           wr_kind_i,
    input  logic [W-1:0]         wr_ctrl_i,
    input  logic [W-1:0]         wr_pol_i,
    input  logic [IDXW-1:0]      wr_ta_i,
    input  logic [IDXW-1:0]      wr_tb_i,
    input  logic                 len_we_i,
    input  logic [LW-1:0]        len_i,
    input  logic [AW-1:0]        rd_idx_i,
    output revc_pkg::gate_kind_e rd_kind_o,
    output logic [W-1:0]         rd_ctrl_o,
    output logic [W-1:0]         rd_pol_o,
    output logic [IDXW-1:0]      rd_ta_o,
    output logic [IDXW-1:0]      rd_tb_o,
    output logic [LW-1:0]        len_o,
    output logic [LW-1:0]        cost_o
);
    import revc_pkg::*;

    gate_kind_e      kind_q [DEPTH];
    logic [W-1:0]    ctrl_q [DEPTH];
    logic [W-1:0]    pol_q  [DEPTH];
    logic [IDXW-1:0] ta_q   [DEPTH];
    logic [IDXW-1:0] tb_q   [DEPTH];
    logic [LW-1:0]   len_q;

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    kind_q[e] <= GK_MCT;
                    ctrl_q[e] <= '0;
                    pol_q[e]  <= '0;
                    ta_q[e]   <= '0;
                    tb_q[e]   <= '0;
                end else if (wr_en_i && (wr_addr_i == AW'(e))) begin
                    kind_q[e] <= gate_kind_e'(wr_kind_i);
                    ctrl_q[e] <= wr_ctrl_i;
                    pol_q[e]  <= wr_pol_i;
                    ta_q[e]   <= wr_ta_i;
                    tb_q[e]   <= wr_tb_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we_i) begin
            len_q <= (len_i > LW'(DEPTH)) ? LW'(DEPTH) : len_i;
        end
    end

    // exchange gates are free; every controlled gate costs one
    always_comb begin
        cost_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((LW'(i) < len_q) && (kind_q[i] != GK_XCHG)) begin
                cost_o = cost_o + LW'(1);
            end
        end
    end

    assign rd_kind_o = kind_q[rd_idx_i];
    assign rd_ctrl_o = ctrl_q[rd_idx_i];
    assign rd_pol_o  = pol_q[rd_idx_i];
    assign rd_ta_o   = ta_q[rd_idx_i];
    assign rd_tb_o   = tb_q[rd_idx_i];
    assign len_o     = len_q;

endmodule

// File: rtl/revc_ctrl.sv
module revc_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          reverse_i,
    input  logic [LW-1:0] len_i,
    output logic [AW-1:0] idx_o,
    output logic          load_o,
    output logic          step_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          idle_o
);
    import revc_pkg::*;

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [AW-1:0] idx_q;
    logic          dir_q;
    logic          last_w;

    assign last_w = dir_q ? (idx_q == '0)
                          : (LW'(idx_q) == (len_i - LW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = (len_i == '0) ? ST_DONE : ST_STEP;
            end
            ST_STEP: begin
                if (last_w) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            dir_q <= 1'b0;
        end else if ((state_q == ST_IDLE) && start_i) begin
            dir_q <= reverse_i;
            idx_q <= reverse_i ? AW'(len_i - LW'(1)) : '0;
        end else if (state_q == ST_STEP) begin
            idx_q <= dir_q ? (idx_q - AW'(1)) : (idx_q + AW'(1));
        end
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        idle_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle_o = 1'b1;
                load_o = start_i;
            end
            ST_STEP: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: idle_o = 1'b0;
        endcase
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/revcascade_engine.sv
module revcascade_engine #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int IDXW  = $clog2(W),
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [1:0]      wr_kind,
    input  logic [W-1:0]    wr_ctrl,
    input  logic [W-1:0]    wr_pol,
    input  logic [IDXW-1:0] wr_tgt_a,
    input  logic [IDXW-1:0] wr_tgt_b,
    input  logic            len_we,
    input  logic [LW-1:0]   len_val,
    input  logic            start,
    input  logic            reverse,
    input  logic [W-1:0]    din,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    dout,
    output logic [LW-1:0]   cost,
    output logic [LW-1:0]   depth
);
    import revc_pkg::*;

    logic            idle;
    logic            load;
    logic            step;
    logic [AW-1:0]   idx;
    gate_kind_e      g_kind;
    logic [W-1:0]    g_ctrl;
    logic [W-1:0]    g_pol;
    logic [IDXW-1:0] g_ta;
    logic [IDXW-1:0] g_tb;
    logic [LW-1:0]   prog_len;
    logic [W-1:0]    work_q;
    logic [W-1:0]    work_next;

    revc_prog_store #(
        .W(W), .DEPTH(DEPTH), .IDXW(IDXW), .AW(AW), .LW(LW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en & idle),
        .wr_addr_i (wr_addr),
        .wr_kind_i (wr_kind),
        .wr_ctrl_i (wr_ctrl),
        .wr_pol_i  (wr_pol),
        .wr_ta_i   (wr_tgt_a),
        .wr_tb_i   (wr_tgt_b),
        .len_we_i  (len_we & idle),
        .len_i     (len_val),
        .rd_idx_i  (idx),
        .rd_kind_o (g_kind),
        .rd_ctrl_o (g_ctrl),
        .rd_pol_o  (g_pol),
        .rd_ta_o   (g_ta),
        .rd_tb_o   (g_tb),
        .len_o     (prog_len),
        .cost_o    (cost)
    );

    revc_ctrl #(
        .DEPTH(DEPTH), .AW(AW), .LW(LW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .reverse_i (reverse),
        .len_i     (prog_len),
        .idx_o     (idx),
        .load_o    (load),
        .step_o    (step),
        .busy_o    (busy),
        .done_o    (done),
        .idle_o    (idle)
    );

    revc_gate_apply #(
        .W(W), .IDXW(IDXW)
    ) u_gate (
        .word_i (work_q),
        .kind_i (g_kind),
        .ctrl_i (g_ctrl),
        .pol_i  (g_pol),
        .ta_i   (g_ta),
        .tb_i   (g_tb),
        .word_o (work_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    work_q <= '0;
        else if (load) work_q <= din;
        else if (step) work_q <= work_next;
    end

    assign dout  = work_q;
    assign depth = prog_len;

endmodule

// File: rtl/revc_check.sv
module revc_check #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [W-1:0]  dout,
    input logic [LW-1:0] cost,
    input logic [LW-1:0] depth
);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) || $past(start)));

    a_r8_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dout));

    a_r10_depth_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || done) |=> $stable(depth));

    a_r10_cost_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || done) |=> $stable(cost));

    a_r11_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= LW'(DEPTH));

    a_r9_cost_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cost <= depth);

endmodule

bind revcascade_engine revc_check #(
    .W(W), .DEPTH(DEPTH), .LW(LW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .dout  (dout),
    .cost  (cost),
    .depth (depth)
);

// File: tb/revcascade_engine_test.sv
module revcascade_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [1:0] wr_kind = '0;
    logic [7:0] wr_ctrl = '0;
    logic [7:0] wr_pol = '0;
    logic [2:0] wr_tgt_a = '0;
    logic [2:0] wr_tgt_b = '0;
    logic       len_we = 1'b0;
    logic [4:0] len_val = '0;
    logic       start = 1'b0;
    logic       reverse = 1'b0;
    logic [7:0] din = '0;
    logic       busy;
    logic       done;
    logic [7:0] dout;
    logic [4:0] cost;
    logic [4:0] depth;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    revcascade_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_kind(wr_kind), .wr_ctrl(wr_ctrl), .wr_pol(wr_pol),
        .wr_tgt_a(wr_tgt_a), .wr_tgt_b(wr_tgt_b), .len_we(len_we),
        .len_val(len_val), .start(start), .reverse(reverse), .din(din),
        .busy(busy), .done(done), .dout(dout), .cost(cost), .depth(depth)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [1:0] m_kind [16];
    logic [7:0] m_ctrl [16];
    logic [7:0] m_pol  [16];
    logic [2:0] m_ta   [16];
    logic [2:0] m_tb   [16];
    int         m_len = 0;
    logic [7:0] m_word = '0;
    bit         m_busy = 1'b0;
    bit         m_done = 1'b0;
    int         m_q[$];

    function automatic logic [7:0] m_apply(logic [7:0] w, logic [1:0] k, logic [7:0] c,
                                           logic [7:0] p, logic [2:0] a, logic [2:0] b);
        logic [7:0] r = w;
        bit fire = 1'b1;
        if (k == 2'd0 || k == 2'd1) begin
            for (int i = 0; i < 8; i++) begin
                if (c[i] && i != int'(a) && !(k == 2'd1 && i == int'(b)))
                    if ((w[i] ^ p[i]) == 1'b0) fire = 1'b0;
            end
        end
        case (k)
            2'd0: if (fire) r[a] = ~w[a];
            2'd1: if (fire) begin r[a] = w[b]; r[b] = w[a]; end
            2'd2: begin r[a] = w[b]; r[b] = w[a]; end
            default: if (a != b && (w[b] ^ p[b])) r[a] = ~w[a];
        endcase
        return r;
    endfunction

    function automatic int m_cost();
        int c = 0;
        for (int i = 0; i < m_len; i++) if (m_kind[i] != 2'd2) c++;
        return c;
    endfunction

    always @(posedge clk) begin : mdl
        int g;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_kind[i] = '0; m_ctrl[i] = '0; m_pol[i] = '0; m_ta[i] = '0; m_tb[i] = '0;
            end
            m_len = 0; m_word = '0; m_busy = 1'b0; m_done = 1'b0; m_q.delete();
        end else if (m_busy) begin
            g = m_q.pop_front();
            m_word = m_apply(m_word, m_kind[g], m_ctrl[g], m_pol[g], m_ta[g], m_tb[g]);
            if (m_q.size() == 0) begin m_busy = 1'b0; m_done = 1'b1; end
        end else if (m_done) begin
            m_done = 1'b0;
        end else begin
            if (wr_en) begin
                m_kind[wr_addr] = wr_kind; m_ctrl[wr_addr] = wr_ctrl; m_pol[wr_addr] = wr_pol;
                m_ta[wr_addr] = wr_tgt_a; m_tb[wr_addr] = wr_tgt_b;
            end
            if (len_we) m_len = (int'(len_val) > 16) ? 16 : int'(len_val);
            if (start) begin
                m_word = din;
                m_q.delete();
                for (int i = 0; i < m_len; i++) m_q.push_back(reverse ? (m_len - 1 - i) : i);
                if (m_len == 0) m_done = 1'b1;
                else            m_busy = 1'b1;
            end
        end
    end

    // per-cycle comparison, half a cycle after each rising edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(dout == m_word, "R7 dout vs model", int'(dout), int'(m_word));
            check(done == m_done, "R8 done vs model", int'(done), int'(m_done));
            check(busy == m_busy, "R8 busy vs model", int'(busy), int'(m_busy));
            check(int'(cost) == m_cost(), "R9 cost vs model", int'(cost), m_cost());
            check(int'(depth) == m_len, "R9 depth vs model", int'(depth), m_len);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_gate(input int ad, input int k, input int c, input int p, input int a, input int b);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(ad); wr_kind = 2'(k); wr_ctrl = 8'(c);
        wr_pol = 8'(p); wr_tgt_a = 3'(a); wr_tgt_b = 3'(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        len_we = 1'b1; len_val = 5'(v);
        @(negedge clk);
        len_we = 1'b0;
    endtask

    task automatic run(input int w, input bit rev, output logic [7:0] res, output int lat);
        @(negedge clk);
        din = 8'(w); reverse = rev; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (!done) check(1'b0, "R8 watchdog on done", 0, 1);
        res = dout;
    endtask

    task automatic run_expect(input int w, input bit rev, input int exp, input string tag);
        logic [7:0] r;
        int lat;
        run(w, rev, r, lat);
        check(r == 8'(exp), tag, int'(r), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic [7:0] r2;
        int lat;
        logic [31:0] s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", int'({busy, done}), 0);
        check(dout == 8'h00, "R1 dout after reset", int'(dout), 0);
        check(cost == 5'd0 && depth == 5'd0, "R1 cost/depth after reset", int'({cost, depth}), 0);

        // R2 multi-control inverter
        wr_gate(0, 0, 8'h03, 8'h00, 7, 0);
        set_len(1);
        run(8'h03, 1'b0, r, lat);
        check(r == 8'h83, "R2 both controls true", int'(r), 8'h83);
        check(lat == 1, "R8 latency one gate", lat, 1);
        run_expect(8'h01, 1'b0, 8'h01, "R2 one control false");
        wr_gate(0, 0, 8'h81, 8'h00, 7, 0);
        run_expect(8'h01, 1'b0, 8'h81, "R2 target dropped from mask");
        wr_gate(0, 0, 8'h00, 8'h00, 4, 0);
        run_expect(8'h00, 1'b0, 8'h10, "R2 empty mask flips");

        // R3 polarity
        wr_gate(0, 0, 8'h03, 8'h02, 7, 0);
        run_expect(8'h01, 1'b0, 8'h81, "R3 negated control met");
        run_expect(8'h03, 1'b0, 8'h03, "R3 negated control unmet");

        // R4 single-control inverter
        wr_gate(0, 3, 8'h00, 8'h00, 2, 5);
        run_expect(8'h20, 1'b0, 8'h24, "R4 control high");
        run_expect(8'h00, 1'b0, 8'h00, "R4 control low");
        wr_gate(0, 3, 8'h00, 8'h20, 2, 5);
        run_expect(8'h00, 1'b0, 8'h04, "R4 negated control");
        wr_gate(0, 3, 8'h00, 8'h00, 3, 3);
        run_expect(8'h08, 1'b0, 8'h08, "R4 equal indices no change");

        // R5 controlled swap
        wr_gate(0, 1, 8'h01, 8'h00, 6, 1);
        run_expect(8'h41, 1'b0, 8'h03, "R5 swap when control true");
        run_expect(8'h40, 1'b0, 8'h40, "R5 hold when control false");

        // R6 exchange ignores masks
        wr_gate(0, 2, 8'hFF, 8'hFF, 0, 7);
        run_expect(8'h01, 1'b0, 8'h80, "R6 unconditional swap");

        // R7 order matters, R9 cost/depth
        wr_gate(0, 2, 8'h00, 8'h00, 0, 1);
        wr_gate(1, 0, 8'h01, 8'h00, 2, 0);
        set_len(2);
        @(negedge clk);
        check(cost == 5'd1, "R9 cost excludes exchange", int'(cost), 1);
        check(depth == 5'd2, "R9 depth equals length", int'(depth), 2);
        run_expect(8'h01, 1'b0, 8'h02, "R7 forward order");
        run_expect(8'h01, 1'b1, 8'h06, "R7 reverse order");

        // empty program finishes at once
        set_len(0);
        run(8'h5A, 1'b0, r, lat);
        check(r == 8'h5A && lat == 0, "R8 empty program", int'(lat), 0);

        // full program, R11 saturation, R7 round trip
        s = 32'h1234_5678;
        for (int e = 0; e < 16; e++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            wr_gate(e, int'(s[1:0]), int'(s[9:2]) & 8'h1B, int'(s[17:10]), int'(s[20:18]), int'(s[23:21]));
        end
        set_len(23);
        @(negedge clk);
        check(depth == 5'd16, "R11 length saturates", int'(depth), 16);
        for (int t = 0; t < 4; t++) begin
            run(8'h11 * (t + 3), 1'b0, r, lat);
            check(lat == 16, "R8 latency full program", lat, 16);
            run(r, 1'b1, r2, lat);
            check(r2 == 8'(8'h11 * (t + 3)), "R7 reverse restores word", int'(r2), int'(8'(8'h11 * (t + 3))));
        end

        // R10 writes and start ignored while running
        @(negedge clk);
        din = 8'hC3; reverse = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        len_we = 1'b1; len_val = 5'd3;
        wr_en = 1'b1; wr_addr = 4'd0; wr_kind = 2'd2; wr_tgt_a = 3'd0; wr_tgt_b = 3'd5;
        @(negedge clk);
        len_we = 1'b0; wr_en = 1'b0; start = 1'b1; din = 8'h00;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        r = dout;
        check(depth == 5'd16, "R10 length write ignored", int'(depth), 16);
        run(r, 1'b1, r2, lat);
        check(r2 == 8'hC3, "R10 descriptor write ignored", int'(r2), 8'hC3);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule